// File: doc/BRIEF.md
# Asymmetric-Width Simple Dual-Port RAM

This block is a synchronous memory with one write port and one read port whose data widths differ by a factor of 2^SHIFT, with SHIFT equal to 0, 1 or 2. A build-time mode flag picks the wide side. In one mode a wide write port feeds a narrow read port. In the other mode a narrow write port feeds a wide read port. Both ports share one clock.

The narrow side addresses 2^SHIFT times as many locations as the wide side. A narrow address is a row number followed by SHIFT lane bits in its least significant positions. Lane 0 is always the most significant slice of the wide word. A designer can therefore write a 32-bit word and read it back as four bytes in big-endian order, or do the reverse.

Storage is built from 2^SHIFT narrow banks, one per lane. A wide access touches every bank. A narrow access enables only the bank its lane bits select. No state machine is involved: the datapath is a write steer, the banks, and a read gather. The only added state is the registered lane select on a narrow read port.

Top module: `asym_sdp_ram`

## Requirements
- R1: The wide port's data width is NW·2^SHIFT and the narrow port's is NW, for SHIFT of 0, 1 and 2 in either mode (WIDE_WRITE=1: wide write, narrow read; WIDE_WRITE=0: narrow write, wide read).
- R2: With SHIFT=0 the block acts as an ordinary same-width simple dual-port RAM: a value written to an address reads back unchanged from that address.
- R3: Narrow address = {row, lane}, where lane is the SHIFT least significant bits and row equals the wide address.
- R4: In wide-write mode, narrow lane 0 of a row returns the most significant NW bits of the word written to that row, and lane 2^SHIFT−1 returns the least significant NW bits (SHIFT=1: 0xDEAD at wide row 1 reads 0xDE at narrow 2 and 0xAD at narrow 3).
- R5: In narrow-write mode, a wide read of a row concatenates the lanes with lane 0 most significant, and a narrow write leaves the other lanes of its row unchanged.
- R6: Read data is registered. It changes only on the clock edge after the read address is presented.
- R7: A read and a write to overlapping locations on the same edge return the old contents. The new value appears on the next read.
- R8: No location changes on an edge where wr_en is low, whatever the write address and data are.
- R9: A write to one row leaves the contents of every other row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| wr_en | input | 1 | Write strobe, acts on the rising edge |
| wr_addr | input | WIDE_WRITE ? NAW−SHIFT : NAW | Write address (row, or row plus lane) |
| wr_data | input | WIDE_WRITE ? NW·2^SHIFT : NW | Write data |
| rd_addr | input | WIDE_WRITE ? NAW : NAW−SHIFT | Read address; a read happens on every edge |
| rd_data | output | WIDE_WRITE ? NW : NW·2^SHIFT | Registered read data |

## Verification
Five instances cover SHIFT 0, 1 and 2 in both modes. Wide words such as 0xDEADBEEF, whose byte values are all distinct, are read one lane at a time. This shows whether the lanes come back in the right order, or reversed or shifted. Narrow bytes are then written one at a time and read back as a wide word, followed by a single-lane overwrite, which reveals any write that spills into neighbouring lanes. Same-edge read and write to the same location tells read-before-write apart from write-through. A write to a neighbouring row and a disabled write with live address and data catch faulty row decoding and write gating.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;

    // Bit offset of a narrow lane inside the wide word; lane 0 sits at the top.
    function automatic int slice_lsb(input int lane, input int lanes, input int nw);
        return (lanes - 1 - lane) * nw;
    endfunction

endpackage

// File: rtl/asym_ram_addr_split.sv
module asym_ram_addr_split #(
    parameter  int SHIFT = 1,
    parameter  int ROWW  = 4,
    localparam int LANES = 1 << SHIFT,
    localparam int AW    = ROWW + SHIFT
) (
    input  logic [AW-1:0]    addr,
    output logic [ROWW-1:0]  row,
    output logic [LANES-1:0] lane_sel
);

    // Upper bits select the row, the low SHIFT bits pick one bank.
    assign row      = addr[AW-1:SHIFT];
    assign lane_sel = LANES'(1) << addr[SHIFT-1:0];

endmodule

// File: rtl/asym_ram_bank.sv
module asym_ram_bank #(
    parameter  int NW    = 8,
    parameter  int ROWW  = 4,
    localparam int DEPTH = 1 << ROWW
) (
    input  logic            clk,
    input  logic            we,
    input  logic [ROWW-1:0] wrow,
    input  logic [NW-1:0]   wdata,
    input  logic [ROWW-1:0] rrow,
    output logic [NW-1:0]   rdata
);

    logic [NW-1:0] cells [DEPTH];

    // Nonblocking update: a same-edge read sees the previous contents.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[wrow] <= wdata;
        end
        rdata <= cells[rrow];
    end

endmodule

// File: rtl/asym_ram_rd_select.sv
module asym_ram_rd_select #(
    parameter  int NW    = 8,
    parameter  int SHIFT = 1,
    localparam int LANES = 1 << SHIFT
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          lane_sel,
    input  logic [LANES-1:0][NW-1:0]  bank_q,
    output logic [NW-1:0]             data
);

    // The lane choice is delayed to line up with the registered bank output.
    logic [LANES-1:0] sel_q;

    always_ff @(posedge clk) begin
        sel_q <= lane_sel;
    end

    always_comb begin
        data = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sel_q[l]) begin
                data = data | bank_q[l];
            end
        end
    end

endmodule

// File: rtl/asym_ram_rd_concat.sv
module asym_ram_rd_concat #(
    parameter  int NW    = 8,
    parameter  int LANES = 4,
    localparam int WW    = NW * LANES
) (
    input  logic [LANES-1:0][NW-1:0] bank_q,
    output logic [WW-1:0]            data
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign data[asym_ram_pkg::slice_lsb(l, LANES, NW) +: NW] = bank_q[l];
    end

endmodule

// File: rtl/asym_sdp_ram.sv
module asym_sdp_ram #(
    parameter  int NW         = 8,
    parameter  int NAW        = 6,
    parameter  int SHIFT      = 2,
    parameter  bit WIDE_WRITE = 1'b0,
    localparam int LANES      = 1 << SHIFT,
    localparam int WW         = NW * LANES,
    localparam int ROWW       = NAW - SHIFT,
    localparam int WRAW       = WIDE_WRITE ? ROWW : NAW,
    localparam int WDW        = WIDE_WRITE ? WW : NW,
    localparam int RDAW       = WIDE_WRITE ? NAW : ROWW,
    localparam int RDW        = WIDE_WRITE ? NW : WW
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [WRAW-1:0] wr_addr,
    input  logic [WDW-1:0]  wr_data,
    input  logic [RDAW-1:0] rd_addr,
    output logic [RDW-1:0]  rd_data
);

    logic [ROWW-1:0]          wr_row;
    logic [LANES-1:0]         wr_sel;
    logic [ROWW-1:0]          rd_row;
    logic [LANES-1:0][NW-1:0] bank_wd;
    logic [LANES-1:0][NW-1:0] bank_q;

    // Write side: a narrow write enables one bank, a wide write enables all.
    if (!WIDE_WRITE && SHIFT > 0) begin : g_wr_narrow
        asym_ram_addr_split #(
            .SHIFT (SHIFT),
            .ROWW  (ROWW)
        ) u_wr_split (
            .addr     (wr_addr),
            .row      (wr_row),
            .lane_sel (wr_sel)
        );
    end else begin : g_wr_wide
        assign wr_row = wr_addr;
        assign wr_sel = '1;
    end

    // Bank array: one narrow bank per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_bank
        if (WIDE_WRITE) begin : g_wide_slice
            assign bank_wd[l] = wr_data[asym_ram_pkg::slice_lsb(l, LANES, NW) +: NW];
        end else begin : g_narrow_copy
            assign bank_wd[l] = wr_data[NW-1:0];
        end

        asym_ram_bank #(
            .NW   (NW),
            .ROWW (ROWW)
        ) u_bank (
            .clk   (clk),
            .we    (wr_en & wr_sel[l]),
            .wrow  (wr_row),
            .wdata (bank_wd[l]),
            .rrow  (rd_row),
            .rdata (bank_q[l])
        );
    end

    // Read side: a narrow read muxes one bank, a wide read concatenates all.
    if (WIDE_WRITE && SHIFT > 0) begin : g_rd_narrow
        logic [LANES-1:0] rd_sel;

        asym_ram_addr_split #(
            .SHIFT (SHIFT),
            .ROWW  (ROWW)
        ) u_rd_split (
            .addr     (rd_addr),
            .row      (rd_row),
            .lane_sel (rd_sel)
        );

        asym_ram_rd_select #(
            .NW    (NW),
            .SHIFT (SHIFT)
        ) u_rd_select (
            .clk      (clk),
            .lane_sel (rd_sel),
            .bank_q   (bank_q),
            .data     (rd_data)
        );
    end else begin : g_rd_wide
        assign rd_row = rd_addr;

        asym_ram_rd_concat #(
            .NW    (NW),
            .LANES (LANES)
        ) u_rd_concat (
            .bank_q (bank_q),
            .data   (rd_data)
        );
    end

endmodule

// File: rtl/asym_sdp_ram_chk.sv
module asym_sdp_ram_chk #(
    parameter  int NW         = 8,
    parameter  int NAW        = 6,
    parameter  int SHIFT      = 2,
    parameter  bit WIDE_WRITE = 1'b0,
    localparam int LANES      = 1 << SHIFT,
    localparam int WW         = NW * LANES,
    localparam int ROWW       = NAW - SHIFT,
    localparam int WRAW       = WIDE_WRITE ? ROWW : NAW,
    localparam int WDW        = WIDE_WRITE ? WW : NW,
    localparam int RDAW       = WIDE_WRITE ? NAW : ROWW,
    localparam int RDW        = WIDE_WRITE ? NW : WW
) (
    input logic            clk,
    input logic            wr_en,
    input logic [WRAW-1:0] wr_addr,
    input logic [WDW-1:0]  wr_data,
    input logic [RDAW-1:0] rd_addr,
    input logic [RDW-1:0]  rd_data
);

    logic [1:0] age = 2'd0;
    logic       primed;

    always_ff @(posedge clk) begin
        if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end
    assign primed = (age >= 2'd2);

    // Port values from the previous edge.
    logic            pw_en;
    logic [WRAW-1:0] pw_addr;
    logic [WDW-1:0]  pw_data;
    logic [RDAW-1:0] pr_addr;

    always_ff @(posedge clk) begin
        pw_en   <= wr_en;
        pw_addr <= wr_addr;
        pw_data <= wr_data;
        pr_addr <= rd_addr;
    end

    int pw_row;
    int rd_row;

    always_comb begin
        pw_row = WIDE_WRITE ? int'(pw_addr) : (int'(pw_addr) >> SHIFT);
        rd_row = WIDE_WRITE ? (int'(rd_addr) >> SHIFT) : int'(rd_addr);
    end

    AST_HOLD_ACROSS_WRITE: assert property (@(posedge clk) disable iff (!primed)
        (rd_addr == pr_addr && !pw_en) |=> $stable(rd_data))
        else $error("same-edge write leaked into read data"); // R7

    AST_OTHER_ROW_UNTOUCHED: assert property (@(posedge clk) disable iff (!primed)
        (rd_addr == pr_addr && pw_en && rd_row != pw_row) |=> $stable(rd_data))
        else $error("write disturbed another row"); // R9

    if (WIDE_WRITE) begin : g_wide_wr
        int            rd_lane;
        logic [NW-1:0] exp_slice;

        always_comb begin
            rd_lane   = int'(rd_addr) & (LANES - 1);
            exp_slice = NW'(pw_data >> ((LANES - 1 - rd_lane) * NW));
        end

        AST_WIDE_SLICE_VISIBLE: assert property (@(posedge clk) disable iff (!primed)
            (pw_en && rd_row == pw_row) |=> (rd_data == $past(exp_slice)))
            else $error("narrow lane does not match the wide write"); // R4
    end else begin : g_narrow_wr
        int            sh_w;
        logic [WW-1:0] lane_mask;

        always_comb begin
            sh_w      = (LANES - 1 - (int'(pw_addr) & (LANES - 1))) * NW;
            lane_mask = WW'({NW{1'b1}}) << sh_w;
        end

        AST_NARROW_LANE_VISIBLE: assert property (@(posedge clk) disable iff (!primed)
            (pw_en && rd_row == pw_row) |=> (NW'(rd_data >> $past(sh_w)) == $past(pw_data)))
            else $error("wide read misplaces the narrow write"); // R5

        AST_NARROW_OTHER_LANES: assert property (@(posedge clk) disable iff (!primed)
            (pw_en && rd_row == pw_row && rd_addr == pr_addr)
            |=> (((rd_data ^ $past(rd_data)) & ~$past(lane_mask)) == '0))
            else $error("narrow write changed a neighbouring lane"); // R5
    end

endmodule

bind asym_sdp_ram asym_sdp_ram_chk #(
    .NW         (NW),
    .NAW        (NAW),
    .SHIFT      (SHIFT),
    .WIDE_WRITE (WIDE_WRITE)
) u_chk (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/asym_sdp_ram_tb.sv
`timescale 1ns/1ps
module asym_sdp_ram_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Index 0: SHIFT0; 1: SHIFT1 wide-write; 2: SHIFT1 narrow-write;
    // 3: SHIFT2 wide-write; 4: SHIFT2 narrow-write (u_dut).
    logic        we [5];
    logic [5:0]  wa [5];
    logic [31:0] wd [5];
    logic [5:0]  ra [5];

    logic [7:0]  rq0;
    logic [7:0]  rq1;
    logic [15:0] rq2;
    logic [7:0]  rq3;
    logic [31:0] rq4;

    asym_sdp_ram #(.NW(8), .NAW(6), .SHIFT(0), .WIDE_WRITE(1'b1)) u_dut_s0 (
        .clk(clk), .wr_en(we[0]), .wr_addr(wa[0]), .wr_data(wd[0][7:0]),
        .rd_addr(ra[0]), .rd_data(rq0));
    asym_sdp_ram #(.NW(8), .NAW(6), .SHIFT(1), .WIDE_WRITE(1'b1)) u_dut_s1w (
        .clk(clk), .wr_en(we[1]), .wr_addr(wa[1][4:0]), .wr_data(wd[1][15:0]),
        .rd_addr(ra[1]), .rd_data(rq1));
    asym_sdp_ram #(.NW(8), .NAW(6), .SHIFT(1), .WIDE_WRITE(1'b0)) u_dut_s1n (
        .clk(clk), .wr_en(we[2]), .wr_addr(wa[2]), .wr_data(wd[2][7:0]),
        .rd_addr(ra[2][4:0]), .rd_data(rq2));
    asym_sdp_ram #(.NW(8), .NAW(6), .SHIFT(2), .WIDE_WRITE(1'b1)) u_dut_s2w (
        .clk(clk), .wr_en(we[3]), .wr_addr(wa[3][3:0]), .wr_data(wd[3]),
        .rd_addr(ra[3]), .rd_data(rq3));
    asym_sdp_ram #(.NW(8), .NAW(6), .SHIFT(2), .WIDE_WRITE(1'b0)) u_dut (
        .clk(clk), .wr_en(we[4]), .wr_addr(wa[4]), .wr_data(wd[4][7:0]),
        .rd_addr(ra[4][3:0]), .rd_data(rq4));

    function automatic logic [31:0] rq_of(input int d);
        case (d)
            0:       return {24'h0, rq0};
            1:       return {24'h0, rq1};
            2:       return {16'h0, rq2};
            3:       return {24'h0, rq3};
            default: return rq4;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int d, input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        we[d] = 1'b1; wa[d] = a; wd[d] = v;
        @(negedge clk);
        we[d] = 1'b0;
    endtask

    task automatic rd(input int d, input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        ra[d] = a;
        @(negedge clk);
        v = rq_of(d);
    endtask

    task automatic rdw(input int d, input logic [5:0] a_w, input logic [31:0] v_w,
                       input logic [5:0] a_r, output logic [31:0] old_v, output logic [31:0] new_v);
        @(negedge clk);
        we[d] = 1'b1; wa[d] = a_w; wd[d] = v_w; ra[d] = a_r;
        @(negedge clk);
        we[d] = 1'b0;
        old_v = rq_of(d);
        @(negedge clk);
        new_v = rq_of(d);
    endtask

    task automatic t_widths;
        check("R1 wide read width",   32'($bits(rq4)), 32'd32);
        check("R1 narrow read width", 32'($bits(rq3)), 32'd8);
        check("R1 shift1 wide width", 32'($bits(rq2)), 32'd16);
    endtask

    task automatic t_equal_width;
        logic [31:0] v;
        wr(0, 6'd5, 32'h5C);
        wr(0, 6'd63, 32'hA1);
        rd(0, 6'd5, v);
        check("R2 equal-width readback", v, 32'h5C);
        @(negedge clk);
        ra[0] = 6'd63;
        #1;
        check("R6 output held before edge", rq_of(0), 32'h5C);
        @(negedge clk);
        check("R6 output after one edge", rq_of(0), 32'hA1);
        wr(0, 6'd6, 32'h33);
        rd(0, 6'd5, v);
        check("R9 neighbour row kept", v, 32'h5C);
    endtask

    task automatic t_wide_write;
        logic [31:0] v;
        wr(1, 6'd1, 32'hDEAD);
        rd(1, 6'd2, v);
        check("R4 shift1 lane0 msb", v, 32'hDE);
        rd(1, 6'd3, v);
        check("R4 shift1 lane1 lsb", v, 32'hAD);
        wr(3, 6'hA, 32'hDEADBEEF);
        wr(3, 6'hB, 32'h01020304);
        rd(3, 6'h28, v);
        check("R4 shift2 lane0", v, 32'hDE);
        rd(3, 6'h29, v);
        check("R3 shift2 lane1", v, 32'hAD);
        rd(3, 6'h2A, v);
        check("R4 shift2 lane2", v, 32'hBE);
        rd(3, 6'h2B, v);
        check("R9 shift2 lane3 after next-row write", v, 32'hEF);
        rd(3, 6'h2C, v);
        check("R3 shift2 next row lane0", v, 32'h01);
    endtask

    task automatic t_narrow_write;
        logic [31:0] v;
        wr(4, 6'h24, 32'hDE);
        wr(4, 6'h25, 32'hAD);
        wr(4, 6'h26, 32'hBE);
        wr(4, 6'h27, 32'hEF);
        rd(4, 6'd9, v);
        check("R5 shift2 assembled word", v, 32'hDEADBEEF);
        wr(4, 6'h26, 32'h11);
        rd(4, 6'd9, v);
        check("R5 single lane overwrite", v, 32'hDEAD11EF);
        wr(2, 6'd6, 32'h12);
        wr(2, 6'd7, 32'h34);
        rd(2, 6'd3, v);
        check("R5 shift1 assembled word", v, 32'h1234);
    endtask

    task automatic t_read_during_write;
        logic [31:0] o;
        logic [31:0] n;
        rdw(4, 6'h24, 32'h77, 6'd9, o, n);
        check("R7 narrow-write old word", o, 32'hDEAD11EF);
        check("R7 narrow-write new word", n, 32'h77AD11EF);
        rdw(3, 6'hA, 32'hAABBCCDD, 6'h29, o, n);
        check("R7 wide-write old lane", o, 32'hAD);
        check("R7 wide-write new lane", n, 32'hBB);
        rdw(0, 6'd5, 32'h99, 6'd5, o, n);
        check("R7 equal-width old", o, 32'h5C);
        check("R7 equal-width new", n, 32'h99);
    endtask

    task automatic t_no_enable;
        logic [31:0] v;
        @(negedge clk);
        we[1] = 1'b0; wa[1] = 6'd1; wd[1] = 32'hFFFF;
        @(negedge clk);
        rd(1, 6'd2, v);
        check("R8 disabled wide write", v, 32'hDE);
        @(negedge clk);
        we[4] = 1'b0; wa[4] = 6'h27; wd[4] = 32'h55;
        @(negedge clk);
        rd(4, 6'd9, v);
        check("R8 disabled narrow write", v, 32'h77AD11EF);
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin
            we[i] = 1'b0; wa[i] = '0; wd[i] = '0; ra[i] = '0;
        end
        repeat (3) @(negedge clk);
        t_widths();
        t_equal_width();
        t_wide_write();
        t_narrow_write();
        t_read_during_write();
        t_no_enable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule